// File: doc/BRIEF.md
# Serial Converter Command and Readout Controller

This block is the digital side of a 12-bit serial successive-approximation converter. A host selects the device with an active-low select line. It then toggles a serial clock and shifts in an 8-bit command, most significant bit first. In the same frame the block returns the result of the conversion before this one on its serial output. The command picks one of 14 sources, eleven external channels and three internal test levels, and sets how the next result is presented: the frame length, the bit order and the output coding.

The analog sampler and the capacitor array are not modelled. The block raises a sample-window output that covers the acquisition interval and presents the selected source on an address output. When the frame is complete it runs a conversion timer counted in system-clock cycles. At the end of the timer it takes the result from a parallel input and raises the end-of-conversion flag. All host pins are brought into the system clock domain through synchronisers, and edges are found from registered samples of those pins.

Top module: `sadc_ctrl`

## Requirements
- R1: After reset, eoc_o is 1, sdo_en_o and sdo_o are 0, sample_o is 0 and addr_o is 0. The stored result is all zeros, so the first frame reads zeros.
- R2: While cs_ni is high, sdo_en_o is 0 and sdo_o is 0, and sclk_i and sdi_i have no effect on addr_o, sample_o or eoc_o. A falling cs_ni clears the frame counters and drives the first stored result bit with sdo_en_o high.
- R3: Command bits are taken MSB first on rising sclk_i edges. The byte layout is [7:4] source address, [3:2] length code, [1] LSB-first, [0] bipolar. addr_o takes the new address once the fourth rising edge has been seen.
- R4: Each falling sclk_i edge moves sdo_o to the next result bit. In 12-bit MSB-first format the result is sent from bit 11 down to bit 0.
- R5: With LSB-first set, the result is sent from bit 0 up to bit 11. The 16-bit length code 11 adds four zeros after the twelve result bits.
- R6: Length code 01 makes the frame 8 clocks long and stores only result bits 11..4 for readout. Codes 00 and 10 give 12 clocks, and code 11 gives 16 clocks. Bit positions past the stored length read as 0.
- R7: With the bipolar bit set, the most significant result bit is inverted before it is sent.
- R8: For a legal address, sample_o goes high on the fourth falling sclk_i edge and low on the last falling edge of the frame.
- R9: On the last falling edge, eoc_o goes low for CONV_CYCLES system clocks. It then returns high with res_i captured, in the format of that frame's command.
- R10: Addresses 14 and 15 are reserved. A frame that carries one opens no sample window and starts no conversion. eoc_o stays high, and addr_o and the stored result keep their values.
- R11: If cs_ni rises before the last falling edge, the frame is abandoned. sample_o returns low, no conversion starts, and the stored result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Device select, active low |
| sclk_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Serial command input |
| res_i | input | 12 | Result value standing in for the analog conversion |
| sdo_o | output | 1 | Serial result output |
| sdo_en_o | output | 1 | Output-driver enable; low means high impedance |
| eoc_o | output | 1 | End-of-conversion flag, low while busy |
| sample_o | output | 1 | Acquisition window |
| addr_o | output | 4 | Currently selected source |

## Verification
The bench builds the block with CONV_CYCLES set to 40 and leaves the two-stage synchronisers at their default. With that setting a whole conversion fits between one frame and the next. Both edges of the busy interval can be sampled with margin on each side, so all formats can be chained within one run. The frames cover every length code, both bit orders, bipolar coding, a reserved address and an abandoned frame. Each frame reads back the result that the previous command produced.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int unsigned RES_W    = 12;
  localparam int unsigned SEQ_W    = 16;
  localparam int unsigned SHORT_W  = 8;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned SRC_LAST = 13;

  typedef enum logic [1:0] {
    LEN_12A = 2'b00,
    LEN_8   = 2'b01,
    LEN_12B = 2'b10,
    LEN_16  = 2'b11
  } len_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    len_e              len;
    logic              lsb_first;
    logic              bipolar;
  } cmd_t;

  function automatic logic [4:0] frame_bits(len_e l);
    case (l)
      LEN_8:   return 5'(SHORT_W);
      LEN_16:  return 5'(SEQ_W);
      default: return 5'(RES_W);
    endcase
  endfunction

  // seq[k] is the k-th bit put on the serial line
  function automatic logic [SEQ_W-1:0] build_seq(logic [RES_W-1:0] r, cmd_t c);
    logic [RES_W-1:0] v;
    logic [SEQ_W-1:0] s;
    v = r;
    s = '0;
    if (c.bipolar) v[RES_W-1] = ~v[RES_W-1];
    for (int k = 0; k < SEQ_W; k++) begin
      if (c.len == LEN_8) begin
        if (k < SHORT_W) s[k] = c.lsb_first ? v[RES_W-SHORT_W+k] : v[RES_W-1-k];
      end else if (k < RES_W) begin
        s[k] = c.lsb_first ? v[k] : v[RES_W-1-k];
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdi_s_i,
  input  logic [SEQ_W-1:0]  seq_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              sample_o,
  output logic              launch_o,
  output logic [ADDR_W-1:0] addr_o,
  output cmd_t              cmd_o
);
  localparam int unsigned CNT_W = $clog2(SEQ_W + 1);
  localparam int unsigned IDX_W = $clog2(SEQ_W);
  localparam logic [CNT_W-1:0] CMD_N     = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] SEQ_N     = CNT_W'(SEQ_W);
  localparam logic [CNT_W-1:0] ADDR_EDGE = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CMD_EDGE  = CNT_W'(CMD_W - 1);
  localparam logic [ADDR_W-1:0] SRC_MAX  = ADDR_W'(SRC_LAST);

  logic cs_q, sclk_q, en_q, active_q, cmd_full_q, addr_ok_q, sample_q, launch_q;
  logic [CNT_W-1:0]  rise_cnt_q, fall_cnt_q;
  logic [CMD_W-1:0]  shift_q, shift_nxt;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  cmd_t              cmd_q;
  logic cs_fall, cs_rise, clk_rise, clk_fall, last_fall;

  assign cs_fall   = cs_q & ~cs_n_s_i;
  assign cs_rise   = ~cs_q & cs_n_s_i;
  assign clk_rise  = active_q & ~cs_n_s_i & sclk_s_i & ~sclk_q;
  assign clk_fall  = active_q & ~cs_n_s_i & ~sclk_s_i & sclk_q;
  assign shift_nxt = {shift_q[CMD_W-2:0], sdi_s_i};
  assign addr_nxt  = shift_nxt[ADDR_W-1:0];
  assign last_fall = clk_fall & cmd_full_q &
                     (CNT_W'(fall_cnt_q + 1'b1) == CNT_W'(frame_bits(cmd_q.len)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b1;
      sclk_q     <= 1'b0;
      en_q       <= 1'b0;
      active_q   <= 1'b0;
      cmd_full_q <= 1'b0;
      addr_ok_q  <= 1'b0;
      sample_q   <= 1'b0;
      launch_q   <= 1'b0;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
      shift_q    <= '0;
      addr_q     <= '0;
      cmd_q      <= '0;
    end else begin
      cs_q     <= cs_n_s_i;
      sclk_q   <= sclk_s_i;
      launch_q <= 1'b0;
      if (cs_fall) begin
        en_q       <= 1'b1;
        active_q   <= 1'b1;
        rise_cnt_q <= '0;
        fall_cnt_q <= '0;
        shift_q    <= '0;
        cmd_full_q <= 1'b0;
        addr_ok_q  <= 1'b0;
        sample_q   <= 1'b0;
      end else if (cs_rise) begin
        en_q     <= 1'b0;
        active_q <= 1'b0;
        sample_q <= 1'b0;
      end else begin
        if (clk_rise && rise_cnt_q < CMD_N) begin
          shift_q    <= shift_nxt;
          rise_cnt_q <= rise_cnt_q + 1'b1;
          if (rise_cnt_q == ADDR_EDGE) begin
            addr_ok_q <= (addr_nxt <= SRC_MAX);
            if (addr_nxt <= SRC_MAX) addr_q <= addr_nxt;
          end
          if (rise_cnt_q == CMD_EDGE) begin
            cmd_q      <= cmd_t'(shift_nxt);
            cmd_full_q <= 1'b1;
          end
        end
        if (clk_fall) begin
          if (fall_cnt_q < SEQ_N) fall_cnt_q <= fall_cnt_q + 1'b1;
          if (fall_cnt_q == ADDR_EDGE && addr_ok_q) sample_q <= 1'b1;
          if (last_fall) begin
            sample_q <= 1'b0;
            active_q <= 1'b0;
            launch_q <= addr_ok_q;
          end
        end
      end
    end
  end

  assign sdo_en_o = en_q;
  assign sdo_o    = en_q & (fall_cnt_q < SEQ_N) & seq_i[fall_cnt_q[IDX_W-1:0]];
  assign sample_o = sample_q;
  assign launch_o = launch_q;
  assign addr_o   = addr_q;
  assign cmd_o    = cmd_q;

  a_r8_launch_ends_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> $past(sample_q));
  a_r10_launch_legal_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (cmd_q.addr <= SRC_MAX));
  a_r2_idle_counters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cs_fall) |=> $stable(rise_cnt_q));
  a_r3_addr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= SRC_MAX);
endmodule

// File: rtl/sadc_conv.sv
module sadc_conv
  import sadc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  cmd_t             cmd_i,
  input  logic [RES_W-1:0] res_i,
  output logic             eoc_o,
  output logic [SEQ_W-1:0] seq_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  cmd_t             fmt_q;
  logic             eoc_q;
  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fmt_q <= '0;
      eoc_q <= 1'b1;
      seq_q <= '0;
    end else if (launch_i) begin
      cnt_q <= CNT_W'(CONV_CYCLES);
      fmt_q <= cmd_i;
      eoc_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        eoc_q <= 1'b1;
        seq_q <= build_seq(res_i, fmt_q);
      end
    end
  end

  assign eoc_o = eoc_q;
  assign seq_o = seq_q;

  a_r9_eoc_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(eoc_o) |-> $past(launch_i));
  a_r9_busy_after_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> !eoc_o);
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 400,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic              eoc_o,
  output logic              sample_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [2:0]       pins_s;
  logic             launch;
  cmd_t             cmd;
  logic [SEQ_W-1:0] seq;

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  sadc_frame u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_s_i(pins_s[2]),
    .sclk_s_i(pins_s[1]),
    .sdi_s_i (pins_s[0]),
    .seq_i   (seq),
    .sdo_o   (sdo_o),
    .sdo_en_o(sdo_en_o),
    .sample_o(sample_o),
    .launch_o(launch),
    .addr_o  (addr_o),
    .cmd_o   (cmd)
  );

  sadc_conv #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .cmd_i   (cmd),
    .res_i   (res_i),
    .eoc_o   (eoc_o),
    .seq_o   (seq)
  );

  a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_en_o |-> !sdo_o);
endmodule

// File: tb/sim_sadc_ctrl.sv
module sim_sadc_ctrl;
  localparam int CONV = 40;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs_n, sclk, sdi;
  logic [11:0] res;
  logic sdo, sdo_en, eoc, sample;
  logic [3:0] addr;

  sadc_ctrl #(.CONV_CYCLES(CONV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .res_i(res), .sdo_o(sdo), .sdo_en_o(sdo_en), .eoc_o(eoc),
    .sample_o(sample), .addr_o(addr)
  );

  int checks = 0, errors = 0;
  int push_n = 0, pop_n = 0;
  bit finished = 0;
  typedef struct { logic v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [15:0] cur_seq = '0;
  logic [3:0]  exp_addr = '0;

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_seq(logic [11:0] r, logic [7:0] c);
    logic [11:0] v;
    logic [15:0] s;
    v = r;
    s = '0;
    if (c[0]) v[11] = ~v[11];
    for (int k = 0; k < 16; k++) begin
      if (c[3:2] == 2'b01) begin
        if (k < 8) s[k] = c[1] ? v[4+k] : v[11-k];
      end else if (k < 12) begin
        s[k] = c[1] ? v[k] : v[11-k];
      end
    end
    return s;
  endfunction

  function automatic int model_len(logic [7:0] c);
    case (c[3:2])
      2'b01:   return 8;
      2'b11:   return 16;
      default: return 12;
    endcase
  endfunction

  // monitor: pops expected serial bits and compares them with the pin
  initial begin
    exp_t e;
    forever begin
      wait (push_n != pop_n);
      e = exp_q.pop_front();
      pop_n++;
      checks++;
      if (sdo_en !== 1'b1 || sdo !== e.v) begin
        errors++;
        $display("FAIL %s sdo actual=%0b en=%0b expected=%0b", e.tag, sdo, sdo_en, e.v);
      end
    end
  end

  // driver: one frame; nclk < frame length abandons it
  task automatic frame(input logic [7:0] cmd, input int nclk, input string tag,
                       input string idle_tag);
    exp_t e;
    bit   ok;
    bit   launch;
    int   flen;
    ok     = (cmd[7:4] <= 4'd13);
    flen   = model_len(cmd);
    launch = ok && (nclk == flen);
    cs_n = 1'b0;
    clocks(HALF);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 8) ? cmd[7-i] : 1'b0;
      clocks(HALF);
      e.v = cur_seq[i];
      e.tag = tag;
      exp_q.push_back(e);
      push_n++;
      chk("R8 sample window", 32'(sample), 32'(ok && i >= 4));
      if (i == 4) begin
        if (ok) exp_addr = cmd[7:4];
        chk(ok ? "R3 address" : "R10 address kept", 32'(addr), 32'(exp_addr));
      end
      sclk = 1'b1;
      clocks(HALF);
      sclk = 1'b0;
    end
    clocks(HALF);
    chk("R8 window after last edge", 32'(sample), 32'(ok && nclk >= 4 && nclk < flen));
    chk(launch ? "R9 eoc low" : idle_tag, 32'(eoc), 32'(!launch));
    cs_n = 1'b1;
    clocks(HALF);
    chk("R11 window closed by deselect", 32'(sample), 32'h0);
    chk("R2 driver off", 32'({sdo_en, sdo}), 32'h0);
    if (launch) begin
      clocks(16);
      chk("R9 eoc held low", 32'(eoc), 32'h0);
      clocks(16);
      chk("R9 eoc back high", 32'(eoc), 32'h1);
      cur_seq = model_seq(res, cmd);
    end else begin
      clocks(32);
      chk(idle_tag, 32'(eoc), 32'h1);
    end
    clocks(HALF);
  endtask

  initial begin
    clocks(150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; res = '0;
    clocks(5);
    rst_n = 1'b1;
    clocks(4);
    chk("R1 eoc", 32'(eoc), 32'h1);
    chk("R1 driver", 32'({sdo_en, sdo}), 32'h0);
    chk("R1 sample", 32'(sample), 32'h0);
    chk("R1 addr", 32'(addr), 32'h0);

    // R2: clocking while deselected changes nothing
    for (int i = 0; i < 10; i++) begin
      sdi = 1'b1; sclk = 1'b1; clocks(HALF); sclk = 1'b0; clocks(HALF);
    end
    chk("R2 addr untouched", 32'(addr), 32'h0);
    chk("R2 sample untouched", 32'(sample), 32'h0);
    chk("R2 eoc untouched", 32'(eoc), 32'h1);
    chk("R2 driver off", 32'({sdo_en, sdo}), 32'h0);

    res = 12'hA5C; frame(8'h30, 12, "R1 zero readout", "R9");
    res = 12'h3F1; frame(8'hBF, 16, "R4 msb-first readout", "R9");
    res = 12'hC36; frame(8'hCC, 16, "R5 lsb-first padded, R7 bipolar", "R9");
    res = 12'h5A5; frame(8'h54, 8, "R6 short frame", "R9");
    res = 12'hFFF; frame(8'hE0, 12, "R6 short result zero tail", "R10 no conversion");
    res = 12'h001; frame(8'h00, 12, "R10 result kept", "R9");
    res = 12'hEEE; frame(8'h20, 6, "R11 partial read", "R11 no conversion");
    res = 12'h801; frame(8'h73, 12, "R11 result kept", "R9");
    res = 12'h000; frame(8'h10, 12, "R7 bipolar lsb-first", "R9");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule